// File: doc/BRIEF.md
# Infrared SIR pulse encoder and decoder

This block sits between a UART and an infrared transceiver. On the transmit side it watches the UART serial output and marks every zero bit with one short high pulse on the infrared line. A one bit leaves the infrared line low. The pulse is either three sixteenths of a bit period long, or a fixed count of system clocks picked by a 3-bit select input. The shorter fixed widths keep the pulse near the minimum width that receivers accept when the bit rate is slow.

On the receive side the raw infrared input passes through a two-flop synchronizer. Each rising edge pulls the rebuilt serial line low for one full bit cycle of 16 ticks, counted from that edge. When no edge arrives, the line idles high. A pulse of any width, down to a single clock, therefore reads as a zero. Both directions use the 16x bit-rate enable that the UART already uses, so the block has no baud logic of its own.

Top module: `sir_codec`

## Requirements
- R1: When `uart_txd` is 0 at the `tick16` that opens a bit, `ir_txd` rises on that clock edge. The result is exactly one high pulse for that zero bit.
- R2: A bit with `uart_txd` at 1 produces no pulse, and `ir_txd` stays low for the whole bit, including idle time.
- R3: With `width_sel` = 3'b000, each pulse lasts exactly `WIDE_TICKS` (default 3) periods of `tick16`.
- R4: With `width_sel` = n, for n from 1 to 7, each pulse lasts exactly `BASE_COUNT` × 2^n system clocks.
- R5: A bit opens on a `tick16` at which `uart_txd` differs from its value at the previous tick. Without such a change, a bit opens every `TICKS_PER_BIT` ticks, so a run of zero bits gives one pulse per bit.
- R6: A rising edge of the synchronized infrared input drives `uart_rxd` low. The line returns high on the `TICKS_PER_BIT`-th `tick16` after that, and it idles high.
- R7: A receive pulse only one system clock wide still decodes as a zero. It is not filtered out.
- R8: After reset, `ir_txd` is 0 and `uart_rxd` is 1.
- R9: When `ir_txd` is looped back to `ir_rxd_raw`, a UART frame (start bit 0, eight data bits with the LSB first, stop bit 1) is rebuilt bit for bit on `uart_rxd`, for every value of `width_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| uart_txd | input | 1 | Serial output of the UART |
| ir_rxd_raw | input | 1 | Unsynchronized infrared receive line |
| width_sel | input | 3 | Pulse width select: 0 for the tick-based width, 1 to 7 for fixed clock counts |
| ir_txd | output | 1 | Infrared transmit pulse line |
| uart_rxd | output | 1 | Rebuilt serial line toward the UART, idle high |

## Verification
The bench builds the block with `BASE_COUNT` = 1 and asserts `tick16` once every 12 clocks. A bit then lasts 192 clocks, so even the longest fixed pulse (128 clocks at code 7) ends inside its bit. This lets all eight select codes be measured to the exact clock and looped back in one short run. Because the tick width is short, the bench can also place one-clock glitches at several phases of the tick period and time the full 16-tick stretch that each glitch produces.

// File: rtl/sir_pkg.sv
package sir_pkg;
  typedef enum logic {
    PW_TICKS = 1'b0,
    PW_CLOCKS = 1'b1
  } pw_mode_e;

  localparam int unsigned SEL_W = 3;
  localparam int unsigned MAX_SHIFT = (1 << SEL_W) - 1;
endpackage

// File: rtl/sir_sync2.sv
module sir_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;
endmodule

// File: rtl/sir_tx_encoder.sv
module sir_tx_encoder
  import sir_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned WIDE_TICKS    = 3,
  parameter int unsigned BASE_COUNT    = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             uart_txd,
  input  logic [SEL_W-1:0] width_sel,
  output logic             ir_txd
);
  localparam int unsigned PH_W  = $clog2(TICKS_PER_BIT);
  localparam int unsigned CNT_W = $clog2(BASE_COUNT << MAX_SHIFT);
  localparam logic [PH_W-1:0] LAST_PH  = PH_W'(TICKS_PER_BIT - 1);
  localparam logic [PH_W-1:0] WIDE_END = PH_W'(WIDE_TICKS - 1);

  logic             last_txd_q, last_txd_n;
  logic [PH_W-1:0]  ph_q, ph_n;
  logic             ir_q, ir_n;
  pw_mode_e         mode_q, mode_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] clk_load;
  logic             bit_open;
  logic             pulse_start;

  // Wraps to the right value when BASE_COUNT << MAX_SHIFT equals 2**CNT_W.
  assign clk_load    = (CNT_W'(BASE_COUNT) << width_sel) - CNT_W'(1);
  assign bit_open    = tick16 && ((uart_txd != last_txd_q) || (ph_q == LAST_PH));
  assign pulse_start = bit_open && !uart_txd;

  always_comb begin
    last_txd_n = last_txd_q;
    ph_n       = ph_q;
    ir_n       = ir_q;
    mode_n     = mode_q;
    cnt_n      = cnt_q;
    if (tick16) begin
      last_txd_n = uart_txd;
      ph_n       = bit_open ? '0 : ph_q + PH_W'(1);
    end
    if (pulse_start) begin
      ir_n   = 1'b1;
      mode_n = (width_sel == '0) ? PW_TICKS : PW_CLOCKS;
      cnt_n  = clk_load;
    end else if (ir_q) begin
      if (mode_q == PW_TICKS) begin
        if (tick16 && (ph_q == WIDE_END)) ir_n = 1'b0;
      end else if (cnt_q == '0) begin
        ir_n = 1'b0;
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_txd_q <= 1'b1;
      ph_q       <= LAST_PH;
      ir_q       <= 1'b0;
      mode_q     <= PW_TICKS;
      cnt_q      <= '0;
    end else begin
      last_txd_q <= last_txd_n;
      ph_q       <= ph_n;
      ir_q       <= ir_n;
      mode_q     <= mode_n;
      cnt_q      <= cnt_n;
    end
  end

  assign ir_txd = ir_q;
endmodule

// File: rtl/sir_rx_decoder.sv
module sir_rx_decoder #(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic rx_level,
  output logic uart_rxd
);
  localparam int unsigned TC_W = $clog2(TICKS_PER_BIT);
  localparam logic [TC_W-1:0] LAST_TC = TC_W'(TICKS_PER_BIT - 1);

  logic            prev_q, prev_n;
  logic            busy_q, busy_n;
  logic [TC_W-1:0] tc_q, tc_n;
  logic            rise;

  assign rise = rx_level && !prev_q;

  always_comb begin
    prev_n = rx_level;
    busy_n = busy_q;
    tc_n   = tc_q;
    if (!busy_q) begin
      if (rise) begin
        busy_n = 1'b1;
        tc_n   = '0;
      end
    end else if (tick16) begin
      if (tc_q == LAST_TC) busy_n = 1'b0;
      else                 tc_n   = tc_q + TC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      busy_q <= 1'b0;
      tc_q   <= '0;
    end else begin
      prev_q <= prev_n;
      busy_q <= busy_n;
      tc_q   <= tc_n;
    end
  end

  assign uart_rxd = !busy_q;
endmodule

// File: rtl/sir_codec.sv
module sir_codec #(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned WIDE_TICKS    = 3,
  parameter int unsigned BASE_COUNT    = 28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       uart_txd,
  input  logic       ir_rxd_raw,
  input  logic [2:0] width_sel,
  output logic       ir_txd,
  output logic       uart_rxd
);
  logic rx_level;

  sir_tx_encoder #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .WIDE_TICKS   (WIDE_TICKS),
    .BASE_COUNT   (BASE_COUNT)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick16   (tick16),
    .uart_txd (uart_txd),
    .width_sel(width_sel),
    .ir_txd   (ir_txd)
  );

  sir_sync2 u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(ir_rxd_raw),
    .q_sync (rx_level)
  );

  sir_rx_decoder #(
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick16  (tick16),
    .rx_level(rx_level),
    .uart_rxd(uart_rxd)
  );
endmodule

// File: rtl/sir_codec_chk.sv
module sir_codec_chk #(
  parameter int unsigned WIDE_TICKS = 3,
  parameter int unsigned BASE_COUNT = 28
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       uart_txd,
  input logic [2:0] width_sel,
  input logic       ir_txd,
  input logic       uart_rxd,
  input logic       rx_level
);
  int unsigned hi_ticks;
  int unsigned hi_clks;
  logic        wide_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ticks <= 0;
      hi_clks  <= 0;
      wide_q   <= 1'b1;
    end else begin
      if (!ir_txd) begin
        hi_ticks <= 0;
        hi_clks  <= 0;
      end else begin
        hi_clks <= hi_clks + 1;
        if (tick16) hi_ticks <= hi_ticks + 1;
      end
      if (tick16 && !uart_txd) wide_q <= (width_sel == 3'b000);
    end
  end

  assert_rise_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_txd) |-> $past(tick16));

  assert_no_pulse_on_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_txd) |-> !$past(uart_txd));

  assert_wide_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_txd && wide_q) |-> (hi_ticks < WIDE_TICKS));

  assert_short_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_txd && !wide_q) |-> (hi_clks < (BASE_COUNT << 7)));

  assert_release_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uart_rxd) |-> $past(tick16));

  assert_low_after_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uart_rxd) |-> $past(rx_level));
endmodule

bind sir_codec sir_codec_chk #(
  .WIDE_TICKS(WIDE_TICKS),
  .BASE_COUNT(BASE_COUNT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick16   (tick16),
  .uart_txd (uart_txd),
  .width_sel(width_sel),
  .ir_txd   (ir_txd),
  .uart_rxd (uart_rxd),
  .rx_level (rx_level)
);

// File: tb/sir_codec_bench.sv
module sir_codec_bench;
  localparam int TDIV  = 12;
  localparam int BASE  = 1;
  localparam int WIDE  = 3;
  localparam int NVEC  = 8;
  // {width_sel, data byte}
  localparam logic [10:0] VEC [NVEC] = '{
    {3'd0, 8'h00}, {3'd0, 8'hA5}, {3'd1, 8'hFF}, {3'd2, 8'h55},
    {3'd3, 8'h0F}, {3'd4, 8'hC3}, {3'd5, 8'h81}, {3'd7, 8'h3C}
  };

  logic       clk, rst_n, tick16, uart_txd, glitch, loop_en;
  logic [2:0] width_sel;
  logic       ir_txd, uart_rxd, ir_rxd_raw;
  int         checks, errors, tdiv_cnt;
  int         exp_w, hi_len, pulses, bad_w, last_bad;

  assign ir_rxd_raw = loop_en ? ir_txd : glitch;

  sir_codec #(.TICKS_PER_BIT(16), .WIDE_TICKS(WIDE), .BASE_COUNT(BASE)) u_sir_codec (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .uart_txd(uart_txd),
    .ir_rxd_raw(ir_rxd_raw), .width_sel(width_sel),
    .ir_txd(ir_txd), .uart_rxd(uart_rxd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    tick16 = 1'b0;
    tdiv_cnt = 0;
    forever begin
      @(negedge clk);
      tdiv_cnt = (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
      tick16 = (tdiv_cnt == TDIV - 1);
    end
  end

  // Pulse width monitor, sampled at the falling edge
  initial begin
    hi_len = 0; pulses = 0; bad_w = 0; last_bad = 0;
    forever begin
      @(negedge clk);
      if (ir_txd) hi_len++;
      else if (hi_len > 0) begin
        pulses++;
        if (hi_len != exp_w) begin bad_w++; last_bad = hi_len; end
        hi_len = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge clk iff tick16);
  endtask

  task automatic send_frame(input logic [7:0] data, input logic [2:0] sel);
    logic [9:0] frame;
    logic [9:0] got;
    int zeros, p0, b0;
    frame = {1'b1, data, 1'b0};
    zeros = 0;
    for (int i = 0; i < 10; i++) if (!frame[i]) zeros++;
    width_sel = sel;
    exp_w = (sel == 3'd0) ? WIDE * TDIV : BASE * (1 << sel);
    p0 = pulses; b0 = bad_w;
    wait_ticks(1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      uart_txd = frame[i];
      wait_ticks(8);
      @(negedge clk);
      got[i] = uart_rxd;
      wait_ticks(8);
    end
    @(negedge clk);
    uart_txd = 1'b1;
    wait_ticks(32);
    @(negedge clk);
    check(pulses - p0 == zeros, "R1 R2 R5 pulse count", pulses - p0, zeros);
    check(bad_w == b0, sel == 0 ? "R3 pulse width" : "R4 pulse width", last_bad, exp_w);
    check(got == frame, "R9 loopback frame", int'(got), int'(frame));
  endtask

  task automatic glitch_test(input int offset);
    wait_ticks(1);
    repeat (offset) @(negedge clk);
    glitch = 1'b1;
    @(negedge clk);
    glitch = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check(uart_rxd == 1'b0, "R7 glitch decodes as zero", uart_rxd, 0);
    wait_ticks(15);
    @(negedge clk);
    check(uart_rxd == 1'b0, "R6 low through 15 ticks", uart_rxd, 0);
    wait_ticks(1);
    @(negedge clk);
    check(uart_rxd == 1'b1, "R6 high after 16th tick", uart_rxd, 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; exp_w = WIDE * TDIV;
    rst_n = 1'b0; uart_txd = 1'b1; glitch = 1'b0; loop_en = 1'b1; width_sel = 3'd0;
    repeat (5) @(negedge clk);
    check(ir_txd == 1'b0, "R8 reset ir_txd", ir_txd, 0);
    check(uart_rxd == 1'b1, "R8 reset uart_rxd", uart_rxd, 1);
    rst_n = 1'b1;
    wait_ticks(40);
    @(negedge clk);
    check(pulses == 0 && uart_rxd == 1'b1, "R2 idle ones give no pulse", pulses, 0);

    for (int v = 0; v < NVEC; v++) send_frame(VEC[v][7:0], VEC[v][10:8]);
    for (int k = 0; k < 4; k++) send_frame(8'($urandom), 3'(k * 2));

    loop_en = 1'b0;
    wait_ticks(20);
    glitch_test(0);
    glitch_test(5);
    glitch_test(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule